// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block watches a six-pin general-purpose port and raises interrupt requests for a small processor core. It has two sources. The first is an external-interrupt input, taken from one port pin. A 2-bit sense field in a control register selects what triggers it: low level, any change, falling edge or rising edge. The second is a pin-change detector. It sets its flag when any watched pin toggles.

Every raw pin passes through a two-flop synchronizer and then into a sample register. Edges are found by comparing two successive samples, never by looking at the raw inputs. Each source has a pending flag. Hardware clears a flag when the core acknowledges that source's vector, and software clears it by writing a one to the flag bit. A request goes to the core only when the global enable, the source's own enable and its flag are all set.

Interrupts still fire when a pin is driven as an output, so firmware can raise an interrupt by writing the port. The one exception is the gated pin, whose pin-change source works only when that pin is an input. There is no streaming data path, so every pin is plain control or status.

Top module: `pin_irq_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ctrl_rdata_o`, `flags_o`, `ext_req_o` and `pc_req_o` are all zero. The synchronizer and sample stages reset to all ones, which is the idle-high pin state.
- R2: A write with `ctrl_we_i` stores every bit of `ctrl_wdata_i` except bits 7 and 2. Those two bits always read back as zero, so writing 0xFF reads back 0x7B.
- R3: With sense field `ctrl[1:0]` = 00 (low level), the external flag `flags_o[0]` is set in every cycle in which the sampled external pin (pin 2) is low. An acknowledge or clear has no lasting effect while the pin stays low.
- R4: With sense 01 (any change), either edge of pin 2 sets `flags_o[0]`.
- R5: With sense 10 (falling edge), only a high-to-low transition of pin 2 sets `flags_o[0]`. A rising edge does not set it.
- R6: With sense 11 (rising edge), only a low-to-high transition of pin 2 sets `flags_o[0]`. A falling edge does not set it.
- R7: A change on any of pins 0 to 4 sets the pin-change flag `flags_o[1]`, whatever the direction bits say (`pin_dir_i` bit = 1 means output).
- R8: A change on pin 5 sets `flags_o[1]` only when `pin_dir_i[5]` = 0.
- R9: A pin transition driven between two clock edges appears on `flags_o` after the third following rising edge, and not after the second. A pulse held for two clock periods is always caught.
- R10: A flag clears on the edge after its acknowledge (`ack_ext_i`, `ack_pc_i`) or after a `flag_we_i` write with a one in its bit of `flag_wdata_i` (bit 0 = external, bit 1 = pin change). Zero bits in that write have no effect.
- R11: If a new event and a clear reach a flag in the same cycle, the flag stays set.
- R12: `ext_req_o` = `gie_i` & `ext_en_i` & `flags_o[0]`, and `pc_req_o` = `gie_i` & `pc_en_i` & `flags_o[1]`.
- R13: A transition on pin 2 that triggers the external source also sets the pin-change flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 6 | Raw port pin levels (asynchronous) |
| pin_dir_i | input | 6 | Per-pin direction, 1 = output |
| gie_i | input | 1 | Global interrupt enable |
| ext_en_i | input | 1 | External interrupt enable |
| pc_en_i | input | 1 | Pin-change interrupt enable |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read value |
| flag_we_i | input | 1 | Write-one-to-clear strobe for the flags |
| flag_wdata_i | input | 2 | Flag bits to clear |
| ack_ext_i | input | 1 | External vector taken |
| ack_pc_i | input | 1 | Pin-change vector taken |
| flags_o | output | 2 | Pending flags: bit 0 external, bit 1 pin change |
| ext_req_o | output | 1 | External interrupt request |
| pc_req_o | output | 1 | Pin-change interrupt request |

## Verification
Directed cases drive pin 2 through rising edges, falling edges and held low levels under each of the four sense values. These separate the edge-qualified modes from the level mode and from any-change.

Pin 5 is toggled once as an output and once as an input, which shows the direction gate apart from the always-on pins. A two-cycle pulse and a cycle-exact latency probe pin down the synchronizer depth.

A clear timed to land on the same edge as a new event separates set-wins priority from clear-wins priority. A long random run then mixes pin toggles, direction flips, sense rewrites, acknowledges, flag writes and enable changes, and compares the flags and requests against a reference model every cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int CTRL_W = 8;
  // bits 7 and 2 are reserved and never stored
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'h7B;
  localparam int FLAG_EXT = 0;
  localparam int FLAG_PC  = 1;
  localparam int NFLAGS   = 2;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= cur;
  end

  assign chg = cur ^ prev_q;
endmodule

// File: rtl/pin_irq_pc_mask.sv
module pin_irq_pc_mask #(
  parameter int          W         = 6,
  parameter logic [W-1:0] GATE_MASK = 6'b10_0000
) (
  input  logic [W-1:0] chg,
  input  logic [W-1:0] dir,
  output logic         hit
);
  logic [W-1:0] qual;

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (GATE_MASK[i]) begin : g_gated
      assign qual[i] = chg[i] & ~dir[i];
    end else begin : g_free
      assign qual[i] = chg[i] & (dir[i] | ~dir[i]);
    end
  end

  assign hit = |qual;
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NPINS       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_PIN     = 2,
  parameter int GATED_PIN   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  pin_dir_i,
  input  logic              gie_i,
  input  logic              ext_en_i,
  input  logic              pc_en_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              flag_we_i,
  input  logic [NFLAGS-1:0] flag_wdata_i,
  input  logic              ack_ext_i,
  input  logic              ack_pc_i,
  output logic [NFLAGS-1:0] flags_o,
  output logic              ext_req_o,
  output logic              pc_req_o
);
  localparam logic [NPINS-1:0] GATE_MASK = NPINS'(1) << GATED_PIN;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NPINS-1:0]  samp;
  logic [NPINS-1:0]  chg;
  logic              pc_hit;
  logic              ext_hit;
  logic [NFLAGS-1:0] set_v, clr_v, flag_q;
  sense_e            sense;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i & CTRL_WMASK;
  end

  assign sense = sense_e'(ctrl_q[1:0]);

  pin_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(samp)
  );

  pin_irq_edge #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(samp), .chg(chg)
  );

  pin_irq_pc_mask #(.W(NPINS), .GATE_MASK(GATE_MASK)) u_pcmask (
    .chg(chg), .dir(pin_dir_i), .hit(pc_hit)
  );

  always_comb begin
    unique case (sense)
      SENSE_LOW:  ext_hit = ~samp[EXT_PIN];
      SENSE_ANY:  ext_hit = chg[EXT_PIN];
      SENSE_FALL: ext_hit = chg[EXT_PIN] & ~samp[EXT_PIN];
      SENSE_RISE: ext_hit = chg[EXT_PIN] & samp[EXT_PIN];
      default:    ext_hit = 1'b0;
    endcase
  end

  assign set_v[FLAG_EXT] = ext_hit;
  assign set_v[FLAG_PC]  = pc_hit;
  assign clr_v[FLAG_EXT] = ack_ext_i | (flag_we_i & flag_wdata_i[FLAG_EXT]);
  assign clr_v[FLAG_PC]  = ack_pc_i  | (flag_we_i & flag_wdata_i[FLAG_PC]);

  // a fresh event outranks a clear in the same cycle
  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[f] <= 1'b0;
      else if (set_v[f]) flag_q[f] <= 1'b1;
      else if (clr_v[f]) flag_q[f] <= 1'b0;
    end
  end

  assign flags_o      = flag_q;
  assign ctrl_rdata_o = ctrl_q;
  assign ext_req_o    = gie_i & ext_en_i & flag_q[FLAG_EXT];
  assign pc_req_o     = gie_i & pc_en_i  & flag_q[FLAG_PC];
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
  parameter int NPINS   = 6,
  parameter int EXT_PIN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_i,
  input logic             gie_i,
  input logic [7:0]       ctrl_rdata_o,
  input logic             flag_we_i,
  input logic [1:0]       flag_wdata_i,
  input logic             ack_ext_i,
  input logic             ack_pc_i,
  input logic [1:0]       flags_o,
  input logic             ext_req_o,
  input logic             pc_req_o
);
  logic [3:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cyc <= '0;
    else if (cyc != 4'hF) cyc <= cyc + 4'd1;
  end

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata_o[7] == 1'b0) && (ctrl_rdata_o[2] == 1'b0));

  // R10
  ext_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_o[0]) |-> $past(ack_ext_i || (flag_we_i && flag_wdata_i[0])));

  // R10
  pc_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_o[1]) |-> $past(ack_pc_i || (flag_we_i && flag_wdata_i[1])));

  // R12
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (!ext_req_o && !pc_req_o));

  // R9
  pc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 4'd6 && $rose(flags_o[1])) |-> ($past(pin_i, 3) != $past(pin_i, 4)));

  // R5
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 4'd6 && $rose(flags_o[0]) && $past(ctrl_rdata_o[1:0]) == 2'b10)
      |-> (!$past(pin_i[EXT_PIN], 3) && $past(pin_i[EXT_PIN], 4)));

  // R6
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 4'd6 && $rose(flags_o[0]) && $past(ctrl_rdata_o[1:0]) == 2'b11)
      |-> ($past(pin_i[EXT_PIN], 3) && !$past(pin_i[EXT_PIN], 4)));
endmodule

bind pin_irq_unit pin_irq_chk #(.NPINS(NPINS), .EXT_PIN(EXT_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gie_i(gie_i),
  .ctrl_rdata_o(ctrl_rdata_o), .flag_we_i(flag_we_i), .flag_wdata_i(flag_wdata_i),
  .ack_ext_i(ack_ext_i), .ack_pc_i(ack_pc_i), .flags_o(flags_o),
  .ext_req_o(ext_req_o), .pc_req_o(pc_req_o)
);

// File: tb/test_pin_irq_unit.sv
`timescale 1ns/1ps
module test_pin_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pin = 6'h3F, dir = 6'h00;
  logic       gie = 1'b0, ext_en = 1'b0, pc_en = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic       flag_we = 1'b0;
  logic [1:0] flag_wdata = 2'b00;
  logic       ack_ext = 1'b0, ack_pc = 1'b0;
  logic [1:0] flags;
  logic       ext_req, pc_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_irq_unit i_pin_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_dir_i(dir), .gie_i(gie),
    .ext_en_i(ext_en), .pc_en_i(pc_en), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_rdata_o(ctrl_rdata), .flag_we_i(flag_we), .flag_wdata_i(flag_wdata),
    .ack_ext_i(ack_ext), .ack_pc_i(ack_pc), .flags_o(flags),
    .ext_req_o(ext_req), .pc_req_o(pc_req)
  );

  // reference model built from the requirements: three-edge pin latency
  logic [5:0] h1 = 6'h3F, h2 = 6'h3F, h3 = 6'h3F;
  logic [7:0] m_ctrl = 8'h00;
  logic [1:0] m_flags = 2'b00;

  function automatic logic [1:0] next_flags(input logic [1:0] f, input logic [1:0] sense,
      input logic [5:0] cur, input logic [5:0] prv, input logic [5:0] d,
      input logic ae, input logic ap, input logic we, input logic [1:0] wd);
    logic es, ps, ec, pc;
    case (sense)
      2'b00:   es = !cur[2];
      2'b01:   es = cur[2] != prv[2];
      2'b10:   es = prv[2] && !cur[2];
      default: es = !prv[2] && cur[2];
    endcase
    ps = |((cur ^ prv) & {~d[5], 5'h1F});
    ec = ae || (we && wd[0]);
    pc = ap || (we && wd[1]);
    return {ps | (f[1] & ~pc), es | (f[0] & ~ec)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= 6'h3F; h2 <= 6'h3F; h3 <= 6'h3F; m_ctrl <= 8'h00; m_flags <= 2'b00;
    end else begin
      h1 <= pin; h2 <= h1; h3 <= h2;
      if (ctrl_we) m_ctrl <= ctrl_wdata & 8'h7B;
      m_flags <= next_flags(m_flags, m_ctrl[1:0], h2, h3, dir, ack_ext, ack_pc, flag_we, flag_wdata);
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wdata = v; ctrl_we = 1'b1; tick(1); ctrl_we = 1'b0;
  endtask

  task automatic w1c(input logic [1:0] v);
    flag_wdata = v; flag_we = 1'b1; tick(1); flag_we = 1'b0; flag_wdata = 2'b00;
  endtask

  initial begin
    #(20 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20251);
    tick(3);
    #2;
    // R1 reset state while held
    check("R1 ctrl", ctrl_rdata, 8'h00);
    check("R1 flags", {6'b0, flags}, 8'h00);
    check("R1 reqs", {6'b0, ext_req, pc_req}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    tick(1); #2;
    check("R1 after release", {4'b0, ext_req, pc_req, flags}, 8'h00);

    // R2 reserved bits
    @(negedge clk); wr_ctrl(8'hFF); #2;
    check("R2 masked write", ctrl_rdata, 8'h7B);
    @(negedge clk); wr_ctrl(8'h01); #2;
    check("R2 plain write", ctrl_rdata, 8'h01);

    // R9 latency, R4 any-change, R13 shared event
    @(negedge clk); pin[2] = 1'b0;
    tick(2); #2;
    check("R9 not after two edges", {6'b0, flags}, 8'h00);
    tick(1); #2;
    check("R9 set after three edges", {6'b0, flags}, 8'h03);
    check("R13 both flags from pin 2", {6'b0, flags}, 8'h03);

    // R12 request gating
    gie = 1'b0; ext_en = 1'b1; pc_en = 1'b1; #2;
    check("R12 gie off", {6'b0, ext_req, pc_req}, 8'h00);
    gie = 1'b1; #2;
    check("R12 all on", {6'b0, ext_req, pc_req}, 8'h03);
    ext_en = 1'b0; #2;
    check("R12 ext disabled", {6'b0, ext_req, pc_req}, 8'h01);
    ext_en = 1'b1;

    // R10 clearing paths
    @(negedge clk); w1c(2'b00); #2;
    check("R10 zero write no effect", {6'b0, flags}, 8'h03);
    @(negedge clk); w1c(2'b01); #2;
    check("R10 w1c ext only", {6'b0, flags}, 8'h02);
    @(negedge clk); ack_pc = 1'b1; tick(1); ack_pc = 1'b0; #2;
    check("R10 ack pc", {6'b0, flags}, 8'h00);

    // R4 rising edge under any-change
    @(negedge clk); pin[2] = 1'b1; tick(4); #2;
    check("R4 rising in any mode", {7'b0, flags[0]}, 8'h01);
    @(negedge clk); w1c(2'b11);

    // R5 falling only
    @(negedge clk); wr_ctrl(8'h02);
    pin[2] = 1'b0; tick(4); #2;
    check("R5 falling sets", {7'b0, flags[0]}, 8'h01);
    @(negedge clk); w1c(2'b11);
    pin[2] = 1'b1; tick(4); #2;
    check("R5 rising ignored", {7'b0, flags[0]}, 8'h00);
    @(negedge clk); w1c(2'b11);

    // R6 rising only
    @(negedge clk); wr_ctrl(8'h03);
    pin[2] = 1'b0; tick(4); #2;
    check("R6 falling ignored", {7'b0, flags[0]}, 8'h00);
    @(negedge clk); pin[2] = 1'b1; tick(4); #2;
    check("R6 rising sets", {7'b0, flags[0]}, 8'h01);
    @(negedge clk); w1c(2'b11);

    // R3 low level re-triggers through acknowledge
    @(negedge clk); wr_ctrl(8'h00);
    pin[2] = 1'b0; tick(4); #2;
    check("R3 low sets", {7'b0, flags[0]}, 8'h01);
    @(negedge clk); ack_ext = 1'b1; tick(1); ack_ext = 1'b0; #2;
    check("R3 ack while low", {7'b0, flags[0]}, 8'h01);
    @(negedge clk); pin[2] = 1'b1; tick(4);
    ack_ext = 1'b1; tick(1); ack_ext = 1'b0; #2;
    check("R3 clears once high", {7'b0, flags[0]}, 8'h00);
    @(negedge clk); wr_ctrl(8'h01); w1c(2'b11);

    // R7 output pins still trigger, R8 gated pin
    @(negedge clk); dir = 6'h3F; pin[0] = 1'b0; tick(4); #2;
    check("R7 output pin change", {7'b0, flags[1]}, 8'h01);
    @(negedge clk); w1c(2'b11);
    pin[5] = 1'b0; tick(4); #2;
    check("R8 pin 5 as output ignored", {7'b0, flags[1]}, 8'h00);
    @(negedge clk); dir = 6'h00; pin[5] = 1'b1; tick(4); #2;
    check("R8 pin 5 as input", {7'b0, flags[1]}, 8'h01);
    @(negedge clk); w1c(2'b11);

    // R9 two-cycle pulse
    @(negedge clk); pin[3] = 1'b0; tick(2); pin[3] = 1'b1; tick(5); #2;
    check("R9 two-cycle pulse", {7'b0, flags[1]}, 8'h01);

    // R11 set wins over simultaneous clear
    @(negedge clk); pin[1] = 1'b0; tick(2);
    ack_pc = 1'b1; tick(1); ack_pc = 1'b0; #2;
    check("R11 set beats ack", {7'b0, flags[1]}, 8'h01);
    @(negedge clk); ack_pc = 1'b1; tick(1); ack_pc = 1'b0; #2;
    check("R10 ack without event", {7'b0, flags[1]}, 8'h00);

    // random run against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); #2;
      check("R9 model flags", {6'b0, flags}, {6'b0, m_flags});
      check("R12 model reqs", {6'b0, ext_req, pc_req},
            {6'b0, gie & ext_en & m_flags[0], gie & pc_en & m_flags[1]});
      check("R2 model ctrl", ctrl_rdata, m_ctrl);
      for (int b = 0; b < 6; b++) if ($urandom_range(0, 7) == 0) pin[b] = ~pin[b];
      if ($urandom_range(0, 15) == 0) dir = 6'($urandom);
      ctrl_we = ($urandom_range(0, 39) == 0);
      ctrl_wdata = 8'($urandom);
      ack_ext = ($urandom_range(0, 5) == 0);
      ack_pc = ($urandom_range(0, 5) == 0);
      flag_we = ($urandom_range(0, 7) == 0);
      flag_wdata = 2'($urandom);
      if ($urandom_range(0, 9) == 0) {gie, ext_en, pc_en} = 3'($urandom);
    end
    @(negedge clk);
    ctrl_we = 1'b0; ack_ext = 1'b0; ack_pc = 1'b0; flag_we = 1'b0;
    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule